// File: doc/BRIEF.md
# Thirty-Two Line GPIO Controller with Edge Interrupts

This peripheral gives software control over 32 general-purpose lines through a plain 32-bit register bus. Each line can be set as an input or as an output. An output line drives a value held in a data latch. An input line is sampled through a two-flop synchronizer. Reads of that line show the sampled value only while the line's input buffer is enabled.

Each line also feeds an edge detector, whatever its direction. Per line, the detector can be set to catch both edges or falling edges only. A detected edge sets a pending event bit, and software clears that bit by writing a one to it. A single interrupt output is high whenever some pending event is also unmasked.

Every register uses a reversed bit order: line n sits in register bit 31 − n. On the pin side, pin vector index n is line n.

Top module: `gpio32_ctrl`

## Requirements
- R1: Line n (pin index n on `pin_in`, `pin_out`, `pin_oe`) maps to bit 31−n of every register, so line 0 is bit 31 and line 31 is bit 0.
- R2: A direction bit of 1 (register at byte offset 0x00) makes the line an output: `pin_oe` is 1 for that line and `pin_out` carries its data latch bit. A direction bit of 0 leaves `pin_oe` at 0.
- R3: Reading the data register (offset 0x08) returns the latch bit for output lines. For input lines it returns the synchronized pin value when the line's input-enable bit (offset 0x1C) is 1, and 0 otherwise. A pin change shows up in the read value after two rising clock edges.
- R4: Writing the event register (offset 0x0C) clears exactly the bits that are 1 in the written word and leaves every other bit unchanged.
- R5: `irq` is 1 exactly when some bit is set in both the event register and the mask register (offset 0x10, 1 = enabled). An event that is already pending raises `irq` as soon as its mask bit is written to 1.
- R6: An edge-control bit (offset 0x14) of 1 records only falling edges on that line. A bit of 0 records both rising and falling edges.
- R7: If a detected edge and a clearing write hit the same event bit in the same cycle, the bit stays set.
- R8: After reset, every register reads 0, `pin_oe` is 0 and `irq` is 0.
- R9: Offsets 0x04 and 0x18, and any offset not listed in R2–R6, read as 0, and writes to them change nothing.
- R10: Edge detection runs on output lines as well as input lines. The event bit is set on the third rising clock edge after the pin changes.
- R11: A write to the event register never sets a bit. Event bits are set only by detected edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not selected) |
| pin_in | input | 32 | Pin levels, index n = line n |
| pin_out | output | 32 | Driven levels, index n = line n |
| pin_oe | output | 32 | Output enables, index n = line n |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle:
- A write to the event register removes only bits that were written as 1 and have no edge arriving in the same cycle.
- A fresh edge always leaves its event bit set.
- No event bit appears without an edge.
- Falling-only lines never record an event while their input is high.
- An unmasked edge raises the interrupt.
- Output enables move only on direction writes.

The bench scenarios cover the rest:
- the reversed bit mapping;
- how the read-back data mixes latch, pin and enable;
- the three-edge latency;
- reserved offsets;
- a write that clears in the same cycle as an edge arrives.

// File: rtl/gpio32_pkg.sv
package gpio32_pkg;
  localparam int NUM_LINES = 32;
  localparam int ADDR_W    = 6;

  localparam logic [ADDR_W-1:0] OFS_DIR  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_ODR  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_DAT  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_EDG  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_EDG2 = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IBE  = 6'h1C;

  // Register bit index of a line: line 0 sits in the top bit.
  function automatic int line_bit(input int line);
    return NUM_LINES - 1 - line;
  endfunction

  // Convert between pin order and register order (an involution).
  function automatic logic [NUM_LINES-1:0] flip(input logic [NUM_LINES-1:0] v);
    logic [NUM_LINES-1:0] r;
    for (int i = 0; i < NUM_LINES; i++) r[line_bit(i)] = v[i];
    return r;
  endfunction

  // Edge qualifier: falling always counts, rising only when both-edge mode.
  function automatic logic [NUM_LINES-1:0] edge_pick(
      input logic [NUM_LINES-1:0] now_v,
      input logic [NUM_LINES-1:0] old_v,
      input logic [NUM_LINES-1:0] fall_only);
    return (old_v & ~now_v) | (now_v & ~old_v & ~fall_only);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n)      stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_in;
        else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
  import gpio32_pkg::*;
#(
  parameter int WIDTH = NUM_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] fall_only,
  output logic [WIDTH-1:0] hit
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign hit = edge_pick(level, prev_q, fall_only);
endmodule

// File: rtl/gpio32_ctrl.sv
module gpio32_ctrl
  import gpio32_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic                 irq
);
  // Register-order state
  logic [NUM_LINES-1:0] dir_q, dat_q, evt_q, mask_q, ecr_q, ibe_q;
  logic [NUM_LINES-1:0] pin_sync, edge_hit, clr_vec, dat_view;
  logic                 wr_en, dir_wr, mask_wr;

  assign wr_en   = bus_sel & bus_wr;
  assign dir_wr  = wr_en & (bus_addr == OFS_DIR);
  assign mask_wr = wr_en & (bus_addr == OFS_MSK);
  assign clr_vec = (wr_en && bus_addr == OFS_EVT) ? bus_wdata : '0;

  gpio_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (flip(pin_in)),
    .d_out (pin_sync)
  );

  gpio_edge_det #(.WIDTH(NUM_LINES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (pin_sync),
    .fall_only (ecr_q),
    .hit       (edge_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dat_q  <= '0;
      mask_q <= '0;
      ecr_q  <= '0;
      ibe_q  <= '0;
    end else if (wr_en) begin
      unique case (bus_addr)
        OFS_DIR: dir_q  <= bus_wdata;
        OFS_DAT: dat_q  <= bus_wdata;
        OFS_MSK: mask_q <= bus_wdata;
        OFS_EDG: ecr_q  <= bus_wdata;
        OFS_IBE: ibe_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  // New edges take priority over clearing writes
  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~clr_vec) | edge_hit;
  end

  assign dat_view = (dat_q & dir_q) | (pin_sync & ~dir_q & ibe_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        OFS_DIR: bus_rdata = dir_q;
        OFS_DAT: bus_rdata = dat_view;
        OFS_EVT: bus_rdata = evt_q;
        OFS_MSK: bus_rdata = mask_q;
        OFS_EDG: bus_rdata = ecr_q;
        OFS_IBE: bus_rdata = ibe_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = flip(dat_q);
  assign pin_oe  = flip(dir_q);
  assign irq     = |(evt_q & mask_q);
endmodule

// File: rtl/gpio32_checker.sv
module gpio32_checker
  import gpio32_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irq,
  input logic                 dir_wr,
  input logic                 mask_wr,
  input logic [NUM_LINES-1:0] pin_oe,
  input logic [NUM_LINES-1:0] evt_q,
  input logic [NUM_LINES-1:0] ecr_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] pin_sync,
  input logic [NUM_LINES-1:0] edge_hit,
  input logic [NUM_LINES-1:0] clr_vec
);
  assert_quiet_after_reset_R8: assert property (@(posedge clk)
    disable iff (!rst_n) $rose(rst_n) |-> !irq);

  assert_w1c_clears_R4: assert property (@(posedge clk)
    disable iff (!rst_n) 1'b1 |=> ((evt_q & $past(clr_vec & ~edge_hit)) == '0));

  assert_edge_wins_R7: assert property (@(posedge clk)
    disable iff (!rst_n) 1'b1 |=> (($past(edge_hit) & ~evt_q) == '0));

  assert_no_spurious_event_R11: assert property (@(posedge clk)
    disable iff (!rst_n) 1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(edge_hit)) == '0));

  assert_falling_only_R6: assert property (@(posedge clk)
    disable iff (!rst_n) (edge_hit & ecr_q & pin_sync) == '0);

  assert_unmasked_edge_irq_R5: assert property (@(posedge clk)
    disable iff (!rst_n) ((|(edge_hit & mask_q)) && !mask_wr) |=> irq);

  assert_oe_only_on_dir_write_R2: assert property (@(posedge clk)
    disable iff (!rst_n) !dir_wr |=> $stable(pin_oe));
endmodule

bind gpio32_ctrl gpio32_checker u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .dir_wr   (dir_wr),
  .mask_wr  (mask_wr),
  .pin_oe   (pin_oe),
  .evt_q    (evt_q),
  .ecr_q    (ecr_q),
  .mask_q   (mask_q),
  .pin_sync (pin_sync),
  .edge_hit (edge_hit),
  .clr_vec  (clr_vec)
);

// File: tb/test_gpio32_ctrl.sv
module test_gpio32_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio32_ctrl i_gpio32_ctrl (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata, .pin_in, .pin_out, .pin_oe, .irq
  );

  // Register bit of line n, restated: top bit for line 0.
  function automatic logic [31:0] lbit(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  // {addr, write data, expected read-back}
  localparam int NV = 8;
  localparam logic [69:0] VEC [NV] = '{
    {6'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {6'h10, 32'h0000_FFFF, 32'h0000_FFFF},
    {6'h14, 32'h1234_5678, 32'h1234_5678},
    {6'h1C, 32'hFFFF_0000, 32'hFFFF_0000},
    {6'h04, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h18, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h20, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h0C, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic pin_set(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    logic [31:0] r;
    do_reset();

    // R8 reset state
    for (int a = 0; a < 8; a++) begin
      rd(6'(a*4), r);
      check("R8 reset read", r, 32'h0);
    end
    check("R8 irq after reset", {31'h0, irq}, 32'h0);
    check("R8 pin_oe after reset", pin_oe, 32'h0);

    // Register table: R9 reserved offsets, R11 event writes never set
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], r);
      check("R9/R11 table readback", r, VEC[i][31:0]);
    end

    // R1/R2 line 0 output
    do_reset();
    wr(6'h00, lbit(0));
    wr(6'h08, 32'hFFFF_FFFF);
    check("R1/R2 pin_oe line0", pin_oe, 32'h0000_0001);
    check("R2 pin_out line0", {31'h0, pin_out[0]}, 32'h1);
    rd(6'h08, r);
    check("R3 output reads latch, inputs disabled", r, lbit(0));

    // R3 input enable and sync latency
    @(negedge clk);
    pin_in = 32'h0000_0002;
    rd(6'h1C, r);
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h08, r);
    check("R3 input line1 via enable", r, lbit(0) | lbit(1));
    @(negedge clk);
    pin_in = 32'h0000_0000;
    @(posedge clk);
    #1 bus_sel = 1; bus_addr = 6'h08;
    #2 check("R3 one edge after change still old", bus_rdata, lbit(0) | lbit(1));
    @(posedge clk);
    #3 check("R3 two edges after change new", bus_rdata, lbit(0));
    bus_sel = 0;

    // R10 output line edge; R6 both-edge mode
    do_reset();
    wr(6'h00, lbit(0));
    pin_set(32'h0000_0021);           // line 0 and line 5 rise
    rd(6'h0C, r);
    check("R10/R6 rising edges recorded", r, lbit(0) | lbit(5));
    check("R5 masked irq low", {31'h0, irq}, 32'h0);
    wr(6'h10, lbit(5));
    check("R5 pending raises irq on unmask", {31'h0, irq}, 32'h1);
    wr(6'h0C, lbit(5));
    rd(6'h0C, r);
    check("R4 w1c selective", r, lbit(0));
    check("R5 irq drops after clear", {31'h0, irq}, 32'h0);

    // R10 timing: event on third edge
    wr(6'h0C, 32'hFFFF_FFFF);
    @(negedge clk);
    pin_in[6] = 1'b1;
    repeat (2) @(posedge clk);
    #1 bus_sel = 1; bus_addr = 6'h0C;
    #2 check("R10 not yet after two edges", bus_rdata & lbit(6), 32'h0);
    @(posedge clk);
    #3 check("R10 set after three edges", bus_rdata & lbit(6), lbit(6));
    bus_sel = 0;

    // R6 falling-only
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h14, lbit(7));
    pin_set(pin_in | 32'h80);
    rd(6'h0C, r);
    check("R6 falling-only ignores rise", r, 32'h0);
    pin_set(pin_in & ~32'h80);
    rd(6'h0C, r);
    check("R6 falling-only catches fall", r, lbit(7));

    // R7 edge and clear in same cycle (bit 7 pending gets cleared too)
    @(negedge clk);
    pin_in[9] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 6'h0C; bus_wdata = lbit(9) | lbit(7);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    rd(6'h0C, r);
    check("R7 edge wins over clear", r, lbit(9));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule